// File: doc/BRIEF.md
# Stepped VID Reference Sequencer

This block turns a 5-bit voltage-identification code into the digital set-point for a regulator's error amplifier. It acts only on cycles where the switching-clock tick is high. On those ticks it compares the code with the previous sample. A code is taken as the new target only after two consecutive ticks have seen it unchanged. The set-point then walks toward the target by one 25 mV step per tick. Code changes that arrive while the walk is in progress are ignored.

During a walk a busy flag is raised, and the power-good indication is masked by a separate mask output. The all-ones code is a shutdown command. Once it is accepted, a latched no-CPU flag is set and the set-point is frozen, and only reset clears that flag. At reset the set-point is loaded directly from the code on the pins, with no ramp.

Top module: `vid_ref_seq`

## Requirements
- R1: The reference output is an integer millivolt value equal to 1550 - 25*code for codes 0..30. Code 0 gives 1550 and code 30 gives 800.
- R2: While reset (`rst_n` low) is sampled, the reference is loaded directly from the code on `vid`, and `busy`, `pg_mask` and `nocpu` are low. A code of 31 at reset loads 800 mV.
- R3: None of the outputs change on a clock edge where `tick` is low.
- R4: A code is accepted only on a tick where it equals the code sampled on the previous tick. A code that differs at every tick is never accepted.
- R5: When an accepted code (other than 31) differs from the current one, `busy` rises on that tick and the reference keeps its value on that tick.
- R6: While `busy` is high, each tick moves the reference exactly 25 mV toward the target. `busy` falls on the tick at which the reference reaches the target.
- R7: Codes present while `busy` is high are ignored, including code 31. Monitoring restarts after the walk ends, so the earliest new acceptance is on the second tick after `busy` falls.
- R8: `pg_mask` is high exactly when `busy` or `nocpu` is high.
- R9: Accepting code 31 sets `nocpu` and freezes the reference. Later codes have no effect on the reference.
- R10: `nocpu` stays set until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the reference from `vid` |
| tick | input | 1 | One-cycle pulse per switching period |
| vid | input | 5 | Voltage-identification code |
| ref_out | output | 11 | Reference set-point in millivolts |
| busy | output | 1 | Walk toward a new target in progress |
| pg_mask | output | 1 | Power-good masking request |
| nocpu | output | 1 | Latched shutdown-command flag |

## Verification
Two functions can fall on the same tick: the step that ends a walk, and the sampling of the code pins. A new code can also meet the latching of the shutdown command. The bench drives a new code, and then code 31, while a walk is still running. It checks that the walk reaches its original target undisturbed and that `nocpu` stays low. It then counts the ticks after `busy` falls, and requires that acceptance comes no earlier than the second of them.

// File: rtl/vid_ref_pkg.sv
package vid_ref_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_IDX_DN = 2'd1,
      STEP_IDX_UP = 2'd2
   } step_dir_e;

   function automatic step_dir_e pick_dir(input int unsigned cur, input int unsigned tgt);
      if (tgt > cur) return STEP_IDX_UP;
      if (tgt < cur) return STEP_IDX_DN;
      return STEP_HOLD;
   endfunction

endpackage

// File: rtl/vid_code_filter.sv
module vid_code_filter #(
   parameter int VID_W = 5,
   parameter int STABLE_TICKS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [VID_W-1:0] vid_i,
   input  logic             hold_i,
   output logic             acc_o,
   output logic [VID_W-1:0] code_o
);
   localparam int CNT_W = $clog2(STABLE_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(STABLE_TICKS);
   localparam logic [CNT_W-1:0] CNT_NEED = CNT_W'(STABLE_TICKS - 1);

   logic [VID_W-1:0] last_q;
   logic             hist_vld_q;
   logic [CNT_W-1:0] same_cnt_q;
   logic             match;
   logic             enough;

   assign match  = hist_vld_q && (vid_i == last_q);
   assign enough = same_cnt_q >= CNT_NEED;
   assign acc_o  = tick && !hold_i && match && enough;
   assign code_o = vid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q     <= '0;
         hist_vld_q <= 1'b0;
         same_cnt_q <= '0;
      end else if (tick) begin
         if (hold_i) begin
            hist_vld_q <= 1'b0;
            same_cnt_q <= '0;
         end else begin
            last_q     <= vid_i;
            hist_vld_q <= 1'b1;
            if (!match)                 same_cnt_q <= '0;
            else if (same_cnt_q != CNT_SAT) same_cnt_q <= same_cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vid_ref_ramp.sv
module vid_ref_ramp
   import vid_ref_pkg::*;
#(
   parameter int VID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [VID_W-1:0] load_idx_i,
   input  logic             acc_i,
   input  logic [VID_W-1:0] acc_code_i,
   output logic [VID_W-1:0] idx_o,
   output logic             busy_o,
   output logic             nocpu_o,
   output logic             mask_o
);
   localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};

   logic [VID_W-1:0] cur_q, cur_n;
   logic [VID_W-1:0] tgt_q, tgt_n;
   logic             busy_q, busy_n;
   logic             nocpu_q, nocpu_n;
   logic             mask_q;
   step_dir_e        dir;

   assign dir = pick_dir(int'(cur_q), int'(tgt_q));

   always_comb begin
      cur_n   = cur_q;
      tgt_n   = tgt_q;
      busy_n  = busy_q;
      nocpu_n = nocpu_q;
      if (tick && !nocpu_q) begin
         if (busy_q) begin
            unique case (dir)
               STEP_IDX_UP: cur_n = cur_q + 1'b1;
               STEP_IDX_DN: cur_n = cur_q - 1'b1;
               default:     cur_n = cur_q;
            endcase
            busy_n = (cur_n != tgt_q);
         end else if (acc_i) begin
            if (acc_code_i == OFF_CODE) begin
               nocpu_n = 1'b1;
            end else if (acc_code_i != cur_q) begin
               tgt_n  = acc_code_i;
               busy_n = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= load_idx_i;
         tgt_q   <= load_idx_i;
         busy_q  <= 1'b0;
         nocpu_q <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         cur_q   <= cur_n;
         tgt_q   <= tgt_n;
         busy_q  <= busy_n;
         nocpu_q <= nocpu_n;
         mask_q  <= busy_n | nocpu_n;
      end
   end

   assign idx_o   = cur_q;
   assign busy_o  = busy_q;
   assign nocpu_o = nocpu_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/vid_ref_map.sv
module vid_ref_map #(
   parameter int VID_W = 5,
   parameter int REF_W = 11,
   parameter int STEP_MV = 25,
   parameter int TOP_MV = 1550,
   parameter bit OUT_MV = 1'b1
) (
   input  logic [VID_W-1:0] idx_i,
   output logic [REF_W-1:0] ref_o
);
   generate
      if (OUT_MV) begin : g_millivolt
         localparam logic [REF_W-1:0] TOP_V = REF_W'(TOP_MV);
         localparam logic [REF_W-1:0] STEP_V = REF_W'(STEP_MV);
         assign ref_o = TOP_V - STEP_V * REF_W'(idx_i);
      end else begin : g_index
         assign ref_o = REF_W'(idx_i);
      end
   endgenerate
endmodule

// File: rtl/vid_ref_seq.sv
module vid_ref_seq #(
   parameter int VID_W = 5,
   parameter int REF_W = 11,
   parameter int STEP_MV = 25,
   parameter int TOP_MV = 1550,
   parameter int STABLE_TICKS = 1,
   parameter bit OUT_MV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [VID_W-1:0] vid,
   output logic [REF_W-1:0] ref_out,
   output logic             busy,
   output logic             pg_mask,
   output logic             nocpu
);
   localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};
   localparam logic [VID_W-1:0] MAX_IDX = OFF_CODE - 1'b1;
   localparam int LOW_MV = TOP_MV - STEP_MV * ((1 << VID_W) - 2);

   generate
      if (VID_W < 2) begin : g_bad_vid_w
         $error("VID_W must be at least 2");
      end
      if (STABLE_TICKS < 1) begin : g_bad_stable
         $error("STABLE_TICKS must be at least 1");
      end
      if (REF_W < VID_W) begin : g_bad_ref_w
         $error("REF_W must cover the code width");
      end
      if (OUT_MV && (LOW_MV < 0 || TOP_MV >= (1 << REF_W))) begin : g_bad_span
         $error("millivolt span does not fit REF_W");
      end
   endgenerate

   logic [VID_W-1:0] load_idx;
   logic             acc;
   logic [VID_W-1:0] acc_code;
   logic [VID_W-1:0] cur_idx;
   logic             hold;

   assign load_idx = (vid == OFF_CODE) ? MAX_IDX : vid;
   assign hold     = busy | nocpu;

   vid_code_filter #(
      .VID_W(VID_W),
      .STABLE_TICKS(STABLE_TICKS)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .vid_i (vid),
      .hold_i(hold),
      .acc_o (acc),
      .code_o(acc_code)
   );

   vid_ref_ramp #(
      .VID_W(VID_W)
   ) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load_idx_i(load_idx),
      .acc_i     (acc),
      .acc_code_i(acc_code),
      .idx_o     (cur_idx),
      .busy_o    (busy),
      .nocpu_o   (nocpu),
      .mask_o    (pg_mask)
   );

   vid_ref_map #(
      .VID_W  (VID_W),
      .REF_W  (REF_W),
      .STEP_MV(STEP_MV),
      .TOP_MV (TOP_MV),
      .OUT_MV (OUT_MV)
   ) u_map (
      .idx_i(cur_idx),
      .ref_o(ref_out)
   );
endmodule

// File: rtl/vid_ref_seq_chk.sv
module vid_ref_seq_chk #(
   parameter int VID_W = 5,
   parameter int REF_W = 11,
   parameter int STEP_MV = 25,
   parameter int TOP_MV = 1550,
   parameter bit OUT_MV = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [REF_W-1:0] ref_out,
   input logic             busy,
   input logic             pg_mask,
   input logic             nocpu
);
   localparam int STEP_U = OUT_MV ? STEP_MV : 1;
   localparam int HI_U = OUT_MV ? TOP_MV : (1 << VID_W) - 2;
   localparam int LO_U = OUT_MV ? TOP_MV - STEP_MV * ((1 << VID_W) - 2) : 0;

   a_r3_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(ref_out) && $stable(busy) && $stable(nocpu) && $stable(pg_mask)));

   a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick) |=> ((int'(ref_out) == int'($past(ref_out)) + STEP_U) ||
                          (int'(ref_out) + STEP_U == int'($past(ref_out)))));

   a_r8_mask_track: assert property (@(posedge clk) disable iff (!rst_n)
      pg_mask == (busy || nocpu));

   a_r10_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
      nocpu |=> nocpu);

   a_r9_ref_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      nocpu |=> $stable(ref_out));

   a_r7_no_off_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nocpu) |-> !$past(busy));

   a_r1_in_span: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ref_out) >= LO_U) && (int'(ref_out) <= HI_U));
endmodule

bind vid_ref_seq vid_ref_seq_chk #(
   .VID_W  (VID_W),
   .REF_W  (REF_W),
   .STEP_MV(STEP_MV),
   .TOP_MV (TOP_MV),
   .OUT_MV (OUT_MV)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .ref_out(ref_out),
   .busy   (busy),
   .pg_mask(pg_mask),
   .nocpu  (nocpu)
);

// File: tb/tb_vid_ref_seq.sv
`timescale 1ns/1ps
module tb_vid_ref_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [4:0]  vid = 5'd0;
   logic [10:0] ref_out;
   logic        busy, pg_mask, nocpu;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vid_ref_seq dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .vid(vid),
      .ref_out(ref_out), .busy(busy), .pg_mask(pg_mask), .nocpu(nocpu)
   );

   function automatic int mv(input int code);
      return 1550 - 25 * code;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_state(input string tag, input int e_mv, input int e_busy, input int e_off);
      chk({tag, " ref"}, int'(ref_out), e_mv);
      chk({tag, " busy"}, int'(busy), e_busy);
      chk({tag, " nocpu"}, int'(nocpu), e_off);
      chk({tag, " R8 mask"}, int'(pg_mask), (e_busy | e_off));
   endtask

   task automatic do_reset(input logic [4:0] v);
      rst_n = 1'b0; tick = 1'b0; vid = v;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_load();
      do_reset(5'd0);  chk_state("R2 reset code0", 1550, 0, 0);
      do_reset(5'd10); chk_state("R2 reset code10", mv(10), 0, 0);
      do_reset(5'd30); chk_state("R1 code30 low end", 800, 0, 0);
      do_reset(5'd31); chk_state("R2 reset code31", 800, 0, 0);
      do_tick(); do_tick();
      chk_state("R9 off accepted after reset", 800, 0, 1);
   endtask

   task automatic t_ramp_down();
      do_reset(5'd0);
      vid = 5'd3;
      do_tick(); chk_state("R4 first sample", 1550, 0, 0);
      do_tick(); chk_state("R5 accept", 1550, 1, 0);
      do_tick(); chk_state("R6 step1", 1525, 1, 0);
      do_tick(); chk_state("R6 step2", 1500, 1, 0);
      do_tick(); chk_state("R6 arrive", 1475, 0, 0);
      do_tick(); chk_state("R6 settled", 1475, 0, 0);
   endtask

   task automatic t_debounce();
      do_reset(5'd0);
      for (int i = 0; i < 6; i++) begin
         vid = (i % 2 == 0) ? 5'd7 : 5'd8;
         do_tick();
         chk_state("R4 toggling code", 1550, 0, 0);
      end
      do_tick();
      chk_state("R4 stable code accepted", 1550, 1, 0);
   endtask

   task automatic t_no_tick();
      do_reset(5'd0);
      vid = 5'd2;
      repeat (20) @(negedge clk);
      chk_state("R3 no tick", 1550, 0, 0);
      do_tick(); do_tick();
      chk_state("R3 ticks resume", 1550, 1, 0);
   endtask

   task automatic t_ignore_busy();
      do_reset(5'd0);
      vid = 5'd4;
      do_tick(); do_tick();
      chk_state("R5 accept code4", 1550, 1, 0);
      vid = 5'd0;
      do_tick(); chk_state("R7 walk kept 1", 1525, 1, 0);
      do_tick(); do_tick();
      do_tick(); chk_state("R7 original target", 1450, 0, 0);
      do_tick(); chk_state("R7 first tick after walk", 1450, 0, 0);
      do_tick(); chk_state("R7 second tick accepts", 1450, 1, 0);
      do_tick(); chk_state("R6 step up", 1475, 1, 0);
      do_tick(); do_tick();
      do_tick(); chk_state("R6 reach top", 1550, 0, 0);
   endtask

   task automatic t_low_edge();
      do_reset(5'd29);
      chk_state("R1 code29", 825, 0, 0);
      vid = 5'd30;
      do_tick(); do_tick();
      do_tick(); chk_state("R6 one step to floor", 800, 0, 0);
   endtask

   task automatic t_off_in_walk();
      do_reset(5'd0);
      vid = 5'd3;
      do_tick(); do_tick();
      vid = 5'd31;
      do_tick(); do_tick(); do_tick();
      chk_state("R7 off code ignored in walk", 1475, 0, 0);
      do_tick(); chk_state("R7 off sampled", 1475, 0, 0);
      do_tick(); chk_state("R9 off latched", 1475, 0, 1);
   endtask

   task automatic t_off_latch();
      do_reset(5'd5);
      vid = 5'd31;
      do_tick(); do_tick();
      chk_state("R9 latch", mv(5), 0, 1);
      vid = 5'd0;
      for (int i = 0; i < 4; i++) do_tick();
      chk_state("R10 latch holds", mv(5), 0, 1);
      do_reset(5'd0);
      chk_state("R10 cleared by reset", 1550, 0, 0);
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_load();
      t_ramp_down();
      t_debounce();
      t_no_tick();
      t_ignore_busy();
      t_low_edge();
      t_off_in_walk();
      t_off_latch();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule